// File: doc/BRIEF.md
# Synchronous burst address generator

This block is the registered address front end of a cache-style synchronous SRAM. On each rising clock edge it decides whether a new 15-bit word address is captured. There are two active-low address strobes. The controller strobe always loads. The processor strobe loads only while the active-low chip enable is asserted. Each load also samples the three-input chip-select decode and registers a "selected" flag. The type of load is reported as well, so that the write logic can treat the two strobes differently.

After a load into a selected device, the active-low advance input steps a two-bit burst counter by one beat per clock. The counter steers the two least-significant bits of the array address, and the upper 13 bits stay at the loaded value. A static mode pin selects the burst order. In linear order the low bits count up modulo 4 from the loaded value. In interleaved order the counter is XORed with the loaded low bits.

Internally a two-state controller tracks selection. ST_IDLE means no selected burst is active; it is the state after reset and after a load that found the device deselected. ST_ACTIVE means a selected load has occurred. The controller makes three transitions: T_SELECT moves from ST_IDLE to ST_ACTIVE on a selected load. T_DESELECT moves from ST_ACTIVE to ST_IDLE on a deselected load. T_RELOAD stays in ST_ACTIVE on a selected load. With no load the state holds. Advances are applied only in ST_ACTIVE.

Top module: `burst_addr_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, arr_addr is 0, selected is 0 and load_kind is 2'b00.
- R2: When strb_ctrl_n is 0 at a clock edge, the next arr_addr equals addr_in, whatever the value of ce_n.
- R3: When strb_proc_n is 0 and ce_n is 1 (and strb_ctrl_n is 1), nothing is loaded: arr_addr keeps its value and load_kind is 2'b00 in the next cycle.
- R4: load_kind encodes the load taken at the previous edge: 2'b10 when strb_proc_n=0 with ce_n=0 (this includes the case where both strobes are asserted), 2'b01 for a load by strb_ctrl_n alone, and 2'b00 when there is no load.
- R5: At every load, selected becomes 1 exactly when ce_n=0, sel_hi=1 and sel_lo_n=0; otherwise it becomes 0. Between loads it holds its value.
- R6: While selected is 1 and no load occurs, adv_n=0 advances the burst by one beat per edge, and adv_n=1 holds arr_addr.
- R7: With ilv_mode=0 (linear), after k advances the low two bits are (start+k) mod 4, and arr_addr[14:2] stays at the loaded value; the fourth advance returns to the start.
- R8: With ilv_mode=1 (interleaved), after k advances the low two bits are start XOR (k mod 4).
- R9: A load in the same cycle as adv_n=0 takes priority: arr_addr equals the new addr_in and the beat count restarts at zero.
- R10: While selected is 0, adv_n=0 has no effect: arr_addr keeps the loaded value until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 15 | Word address to capture |
| strb_ctrl_n | input | 1 | Controller address strobe, active low, not gated by ce_n |
| strb_proc_n | input | 1 | Processor address strobe, active low, gated by ce_n |
| ce_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| arr_addr | output | 15 | Current array word address |
| selected | output | 1 | Registered selection flag |
| load_kind | output | 2 | Load taken at last edge: 00 none, 01 controller, 10 processor |

## Verification
Two functions can fall in the same cycle. A strobe load can coincide with a burst advance, and the two strobes can coincide with each other. The bench sets up a burst that is part-way through, then drives a new address with adv_n held low. It checks that arr_addr shows the new address with its own low bits, and that the next advance moves the count to the first beat and not further. For the coinciding strobes, it asserts both strobes with ce_n low and expects load_kind 2'b10. With ce_n high it expects 2'b01. In both cases it checks that the address loaded is the same.

// File: rtl/bafe_pkg.sv
package bafe_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } bafe_state_t;

    typedef enum logic [1:0] {
        LK_NONE = 2'b00,
        LK_CTRL = 2'b01,
        LK_PROC = 2'b10
    } load_kind_t;
endpackage

// File: rtl/bafe_decode.sv
module bafe_decode
    import bafe_pkg::*;
(
    input  logic       strb_ctrl_n,
    input  logic       strb_proc_n,
    input  logic       ce_n,
    input  logic       sel_hi,
    input  logic       sel_lo_n,
    output logic       do_load,
    output load_kind_t kind,
    output logic       sel_now
);
    logic proc_ok;
    logic ctrl_ok;

    always_comb begin
        proc_ok = !strb_proc_n && !ce_n;
        ctrl_ok = !strb_ctrl_n;
        do_load = proc_ok || ctrl_ok;
        sel_now = !ce_n && sel_hi && !sel_lo_n;
        if (proc_ok)
            kind = LK_PROC;
        else if (ctrl_ok)
            kind = LK_CTRL;
        else
            kind = LK_NONE;
    end
endmodule

// File: rtl/bafe_ctrl.sv
module bafe_ctrl
    import bafe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_load,
    input  load_kind_t kind,
    input  logic       sel_now,
    input  logic       adv_n,
    output logic       selected,
    output logic [1:0] load_kind,
    output logic       cnt_clr,
    output logic       cnt_step
);
    bafe_state_t state_q;
    bafe_state_t state_d;
    load_kind_t  kind_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= LK_NONE;
        end else begin
            state_q <= state_d;
            kind_q  <= kind;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_clr  = do_load;
        cnt_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (do_load && sel_now)
                    state_d = ST_ACTIVE;           // T_SELECT
            end
            ST_ACTIVE: begin
                if (do_load && !sel_now)
                    state_d = ST_IDLE;             // T_DESELECT
                else if (do_load)
                    state_d = ST_ACTIVE;           // T_RELOAD
                else
                    cnt_step = !adv_n;
            end
            default: state_d = ST_IDLE;
        endcase
        selected  = (state_q == ST_ACTIVE);
        load_kind = kind_q;
    end
endmodule

// File: rtl/bafe_seq.sv
module bafe_seq #(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              do_load,
    input  logic              cnt_clr,
    input  logic              cnt_step,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] arr_addr
);
    localparam int UPPER_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] lin_low;
    logic [BURST_W-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_load)
                base_q <= addr_in;
            if (cnt_clr)
                cnt_q <= '0;
            else if (cnt_step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb lin_low = base_q[BURST_W-1:0] + cnt_q;

    for (genvar i = 0; i < BURST_W; i++) begin : g_low
        assign low_bits[i] = ilv_mode ? (base_q[i] ^ cnt_q[i]) : lin_low[i];
    end

    assign arr_addr = {base_q[ADDR_W-1 -: UPPER_W], low_bits};
endmodule

// File: rtl/burst_addr_front.sv
module burst_addr_front
    import bafe_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_ctrl_n,
    input  logic              strb_proc_n,
    input  logic              ce_n,
    input  logic              sel_hi,
    input  logic              sel_lo_n,
    input  logic              adv_n,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              selected,
    output logic [1:0]        load_kind
);
    logic       do_load;
    logic       sel_now;
    logic       cnt_clr;
    logic       cnt_step;
    load_kind_t kind;

    bafe_decode u_decode (
        .strb_ctrl_n (strb_ctrl_n),
        .strb_proc_n (strb_proc_n),
        .ce_n        (ce_n),
        .sel_hi      (sel_hi),
        .sel_lo_n    (sel_lo_n),
        .do_load     (do_load),
        .kind        (kind),
        .sel_now     (sel_now)
    );

    bafe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_load   (do_load),
        .kind      (kind),
        .sel_now   (sel_now),
        .adv_n     (adv_n),
        .selected  (selected),
        .load_kind (load_kind),
        .cnt_clr   (cnt_clr),
        .cnt_step  (cnt_step)
    );

    bafe_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (addr_in),
        .do_load  (do_load),
        .cnt_clr  (cnt_clr),
        .cnt_step (cnt_step),
        .ilv_mode (ilv_mode),
        .arr_addr (arr_addr)
    );
endmodule

// File: rtl/bafe_checker.sv
module bafe_checker #(
    parameter int ADDR_W  = 15,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strb_ctrl_n,
    input logic              strb_proc_n,
    input logic              ce_n,
    input logic              sel_hi,
    input logic              sel_lo_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              selected,
    input logic [1:0]        load_kind
);
    logic any_load;
    logic want_sel;
    assign any_load = !strb_ctrl_n || (!strb_proc_n && !ce_n);
    assign want_sel = !ce_n && sel_hi && !sel_lo_n;

    a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_ctrl_n |=> arr_addr[ADDR_W-1:BURST_W] == $past(addr_in[ADDR_W-1:BURST_W]));

    a_r3_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctrl_n && !strb_proc_n && ce_n) |=>
            (load_kind == 2'b00) && $stable(arr_addr[ADDR_W-1:BURST_W]));

    a_r4_proc_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !ce_n) |=> load_kind == 2'b10);

    a_r5_select: assert property (@(posedge clk) disable iff (!rst_n)
        any_load |=> selected == $past(want_sel));

    a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(selected));

    a_r9_load_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (any_load && !adv_n) |=> arr_addr == $past(addr_in));

    a_r10_desel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!selected && !any_load) |=> $stable(arr_addr[ADDR_W-1:BURST_W]));
endmodule

bind burst_addr_front bafe_checker #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_bafe_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_in     (addr_in),
    .strb_ctrl_n (strb_ctrl_n),
    .strb_proc_n (strb_proc_n),
    .ce_n        (ce_n),
    .sel_hi      (sel_hi),
    .sel_lo_n    (sel_lo_n),
    .adv_n       (adv_n),
    .arr_addr    (arr_addr),
    .selected    (selected),
    .load_kind   (load_kind)
);

// File: tb/test_burst_addr_front.sv
`timescale 1ns/1ps
module test_burst_addr_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] addr_in = '0;
    logic        strb_ctrl_n = 1'b1;
    logic        strb_proc_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        sel_hi = 1'b0;
    logic        sel_lo_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        ilv_mode = 1'b0;
    logic [14:0] arr_addr;
    logic        selected;
    logic [1:0]  load_kind;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    burst_addr_front i_burst_addr_front (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strb_ctrl_n(strb_ctrl_n), .strb_proc_n(strb_proc_n),
        .ce_n(ce_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
        .adv_n(adv_n), .ilv_mode(ilv_mode),
        .arr_addr(arr_addr), .selected(selected), .load_kind(load_kind)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        strb_ctrl_n = 1'b1; strb_proc_n = 1'b1; adv_n = 1'b1;
    endtask

    // selected load via controller strobe, then idle
    task automatic sel_load(input logic [14:0] a);
        addr_in = a; ce_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        strb_ctrl_n = 1'b0; tick(); idle_in();
    endtask

    task automatic t_reset();
        chk("R1 arr_addr", int'(arr_addr), 0);
        chk("R1 selected", int'(selected), 0);
        chk("R1 load_kind", int'(load_kind), 0);
    endtask

    task automatic t_ctrl_load();
        addr_in = 15'h5A5A; ce_n = 1'b1; strb_ctrl_n = 1'b0; tick(); idle_in();
        chk("R2 ctrl load ce high", int'(arr_addr), 'h5A5A);
        chk("R4 ctrl kind", int'(load_kind), 1);
        tick();
        chk("R4 no-load kind", int'(load_kind), 0);
    endtask

    task automatic t_proc_gated();
        addr_in = 15'h1111; ce_n = 1'b1; strb_proc_n = 1'b0; tick(); idle_in();
        chk("R3 proc ignored addr", int'(arr_addr), 'h5A5A);
        chk("R3 proc ignored kind", int'(load_kind), 0);
        ce_n = 1'b0; strb_proc_n = 1'b0; tick(); idle_in();
        chk("R4 proc load addr", int'(arr_addr), 'h1111);
        chk("R4 proc kind", int'(load_kind), 2);
    endtask

    task automatic t_both();
        addr_in = 15'h2222; ce_n = 1'b0; strb_ctrl_n = 1'b0; strb_proc_n = 1'b0;
        tick(); idle_in();
        chk("R4 both kind ce low", int'(load_kind), 2);
        chk("R4 both addr ce low", int'(arr_addr), 'h2222);
        addr_in = 15'h3333; ce_n = 1'b1; strb_ctrl_n = 1'b0; strb_proc_n = 1'b0;
        tick(); idle_in();
        chk("R4 both kind ce high", int'(load_kind), 1);
        chk("R4 both addr ce high", int'(arr_addr), 'h3333);
    endtask

    task automatic t_select();
        sel_load(15'h0100);
        chk("R5 selected on valid decode", int'(selected), 1);
        sel_hi = 1'b0; tick();
        chk("R5 hold without load", int'(selected), 1);
        strb_ctrl_n = 1'b0; tick(); idle_in();
        chk("R5 sel_hi low deselects", int'(selected), 0);
        sel_load(15'h0100);
        sel_lo_n = 1'b1; strb_ctrl_n = 1'b0; tick(); idle_in();
        chk("R5 sel_lo_n high deselects", int'(selected), 0);
        sel_load(15'h0100);
        ce_n = 1'b1; strb_ctrl_n = 1'b0; tick(); idle_in();
        chk("R5 ce_n high deselects", int'(selected), 0);
    endtask

    task automatic t_order(input logic mode);
        logic [1:0] exp_low;
        ilv_mode = mode;
        sel_load(15'h2A41);
        chk(mode ? "R8 start" : "R7 start", int'(arr_addr), 'h2A41);
        adv_n = 1'b1; tick();
        chk("R6 adv high holds", int'(arr_addr), 'h2A41);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0; tick();
            exp_low = mode ? (2'b01 ^ 2'(k)) : 2'(1 + k);
            chk(mode ? "R8 interleaved beat" : "R7 linear beat",
                int'(arr_addr), int'({13'h0A90, exp_low}));
        end
        adv_n = 1'b1;
    endtask

    task automatic t_priority();
        ilv_mode = 1'b0;
        sel_load(15'h0404);
        adv_n = 1'b0; tick(); tick();
        chk("R9 setup mid burst", int'(arr_addr), 'h0406);
        addr_in = 15'h7FFD; strb_ctrl_n = 1'b0; adv_n = 1'b0; tick();
        strb_ctrl_n = 1'b1;
        chk("R9 load wins over advance", int'(arr_addr), 'h7FFD);
        tick();
        chk("R9 count restarted", int'(arr_addr), 'h7FFE);
        adv_n = 1'b1;
    endtask

    task automatic t_desel_adv();
        addr_in = 15'h0C02; ce_n = 1'b1; strb_ctrl_n = 1'b0; tick(); idle_in();
        adv_n = 1'b0; tick(); tick();
        chk("R10 advance ignored when deselected", int'(arr_addr), 'h0C02);
        chk("R10 still deselected", int'(selected), 0);
        adv_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_load();
        t_proc_gated();
        t_both();
        t_select();
        t_order(1'b0);
        t_order(1'b1);
        t_priority();
        t_desel_adv();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule